// File: doc/BRIEF.md
# Four-Mode Full-Duplex Serial Master

This block is a synchronous serial master for four-wire peripherals. A client presents a transmit word and pulses a start strobe. The engine then drops an active-low select line, generates a serial clock from the system clock, and shifts the word out most significant bit first. While it sends, it shifts a word in from the peripheral. When the last bit has moved, it returns the received word together with a one-cycle completion pulse.

Clock polarity and clock phase are inputs, so any of the four serial modes can be chosen at run time. Each frame is 8 or 16 bits wide. A hold flag, given with the start strobe, keeps the select line low after the frame ends. This lets any number of frames share one select window. The window closes after the first frame that was started with the hold flag low. The serial clock half-period is a fixed number of system clocks set by a parameter.

Top module: `spiModeMaster`

## Requirements
- R1: While `csN` is high, `sck` equals `cpol`. It is also at the `cpol` level at every point of a select window where no frame is running.
- R2: Each frame is sent most significant bit first. With `cpha`=0, `miso` is sampled (and `mosi` captured by the peripheral) on odd serial clock edges counted from the frame start, and `mosi` changes on even edges. With `cpha`=1 these roles swap. Sampling edges are therefore rising when `cpol`==`cpha` and falling otherwise.
- R3: With `cpha`=0, the first transmit bit is on `mosi` by the time `csN` falls. With `cpha`=1, it appears together with the first `sck` edge.
- R4: With H = DIV+1 system clocks, consecutive `sck` edges within a frame are exactly H clocks apart. The first edge comes at least H clocks after `csN` falls or a chained frame is accepted. `csN` rises at least H clocks after the last edge.
- R5: `wide16`=1 selects a 16-bit frame built from `txWord[15:0]`, which takes 32 `sck` edges. `wide16`=0 selects an 8-bit frame built from `txWord[7:0]`, which takes 16 edges. In that case `rxWord[15:8]` reads 0.
- R6: Each completed frame produces a `doneStb` pulse exactly one system clock long. `rxWord` holds the received bits, first-received bit in the most significant used position, during that cycle.
- R7: A `startReq` that arrives while `busy` is high is ignored. It neither restarts the frame nor changes the transmitted bits nor adds a frame.
- R8: A frame started with `holdSel`=1 leaves `csN` low after it ends, with `busy` low. A new `startReq` then runs the next frame in the same window under the same clock mode.
- R9: During reset, `csN` is 1, `busy` is 0, `doneStb` is 0, `mosi` is 0 and `sck` follows `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level, sampled when a window opens |
| cpha | input | 1 | Clock phase select, sampled when a window opens |
| wide16 | input | 1 | 1 for a 16-bit frame, 0 for an 8-bit frame |
| holdSel | input | 1 | Keep select low after this frame |
| txWord | input | 16 | Word to transmit, captured with the start |
| startReq | input | 1 | Start strobe for one frame |
| rxWord | output | 16 | Received word, valid with doneStb |
| doneStb | output | 1 | One-cycle frame completion pulse |
| busy | output | 1 | Frame or select release in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| csN | output | 1 | Active-low select |
| miso | input | 1 | Serial data from the peripheral |

## Verification
With `cpha`=1 the final serial edge both samples the last `miso` bit and completes the word, so the sample and the completion fall in one system cycle. This is provoked in modes 1 and 3 with peripheral words whose last bit differs from the one before it. It is judged by comparing `rxWord` in the `doneStb` cycle against the word the peripheral model sent. A second collision puts a start strobe carrying a different word in the middle of a running frame. It is judged by the bits the peripheral model captures and by the frame and select-release counts.

// File: rtl/spiEngPkg.sv
package spiEngPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL, ST_HOLD} engState_t;

  typedef struct packed {
    logic load;    // capture a new transmit word
    logic prime;   // put the first bit on the line at load time
    logic drive;   // shift the next bit onto the line
    logic sample;  // capture one received bit
    logic finish;  // last edge of the frame
  } engStrobe_t;
endpackage

// File: rtl/spiEngCtrl.sv
module spiEngCtrl
  import spiEngPkg::*;
#(
  parameter int DIV    = 2,
  parameter int NARROW = 8,
  parameter int WIDE   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       holdSel,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       wide16,
  output engStrobe_t strb,
  output logic       csN,
  output logic       sck,
  output logic       busy
);
  localparam int DIVW   = $clog2(DIV + 2);
  localparam int EDGEW  = $clog2(2 * WIDE + 1);
  localparam int EDGE_N = 2 * NARROW;
  localparam int EDGE_W = 2 * WIDE;
  localparam logic [DIVW-1:0] DIV_L = DIVW'(DIV);

  engState_t        state;
  logic [DIVW-1:0]  divCnt;
  logic [EDGEW-1:0] edgeCnt;
  logic [EDGEW-1:0] lastIdx;
  logic phase, csNQ, cpolQ, cphaQ, wideQ, holdQ;
  logic tick, accept, edgeNow, onSample, lastEdge;

  assign tick     = (divCnt == DIV_L);
  assign accept   = startReq && (state == ST_IDLE || state == ST_HOLD);
  assign edgeNow  = (state == ST_RUN) && tick;
  assign onSample = (~edgeCnt[0]) ^ cphaQ;
  assign lastIdx  = wideQ ? EDGEW'(EDGE_W - 1) : EDGEW'(EDGE_N - 1);
  assign lastEdge = edgeNow && (edgeCnt == lastIdx);

  always_comb begin
    strb.load   = accept;
    strb.prime  = accept && !((state == ST_IDLE) ? cpha : cphaQ);
    strb.drive  = edgeNow && !onSample && !lastEdge;
    strb.sample = edgeNow && onSample;
    strb.finish = lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      phase   <= 1'b0;
      csNQ    <= 1'b1;
      cpolQ   <= 1'b0;
      cphaQ   <= 1'b0;
      wideQ   <= 1'b0;
      holdQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          cpolQ   <= cpol;
          cphaQ   <= cpha;
          wideQ   <= wide16;
          holdQ   <= holdSel;
          csNQ    <= 1'b0;
          divCnt  <= '0;
          edgeCnt <= '0;
          state   <= ST_RUN;
        end
        ST_HOLD: if (accept) begin
          wideQ   <= wide16;
          holdQ   <= holdSel;
          divCnt  <= '0;
          edgeCnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          if (tick) begin
            divCnt  <= '0;
            phase   <= ~phase;
            edgeCnt <= edgeCnt + 1'b1;
            if (lastEdge) state <= holdQ ? ST_HOLD : ST_TAIL;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            divCnt <= '0;
            csNQ   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN  = csNQ;
  assign sck  = csNQ ? cpol : (cpolQ ^ phase);
  assign busy = (state == ST_RUN) || (state == ST_TAIL);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAIL || state == ST_HOLD) |-> (sck == cpolQ));

  // R4
  half_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> ($past(divCnt) == DIV_L));

  // R4
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csNQ) |-> ($past(state) == ST_TAIL && $past(divCnt) == DIV_L));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> ($stable(wideQ) && $stable(holdQ) && $stable(cpolQ) && $stable(cphaQ)));
endmodule

// File: rtl/spiEngData.sv
module spiEngData
  import spiEngPkg::*;
#(
  parameter int NARROW = 8,
  parameter int WIDE   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  engStrobe_t      strb,
  input  logic [WIDE-1:0] txWord,
  input  logic            wide16,
  input  logic            miso,
  output logic            mosi,
  output logic [WIDE-1:0] rxWord,
  output logic            doneStb
);
  localparam int PADW = WIDE - NARROW;

  logic [WIDE-1:0] txSh, rxSh, aligned, rxNext;
  logic mosiQ, doneQ, frameWide;
  logic [WIDE-1:0] rxQ;

  assign aligned = wide16 ? txWord : {txWord[NARROW-1:0], {PADW{1'b0}}};
  assign rxNext  = strb.sample ? {rxSh[WIDE-2:0], miso} : rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh      <= '0;
      rxSh      <= '0;
      rxQ       <= '0;
      mosiQ     <= 1'b0;
      doneQ     <= 1'b0;
      frameWide <= 1'b0;
    end else begin
      doneQ <= strb.finish;
      if (strb.load) begin
        frameWide <= wide16;
        rxSh      <= '0;
        if (strb.prime) begin
          mosiQ <= aligned[WIDE-1];
          txSh  <= aligned << 1;
        end else begin
          txSh  <= aligned;
        end
      end else begin
        if (strb.drive) begin
          mosiQ <= txSh[WIDE-1];
          txSh  <= txSh << 1;
        end
        if (strb.sample) rxSh <= rxNext;
      end
      if (strb.finish)
        rxQ <= frameWide ? rxNext : {{PADW{1'b0}}, rxNext[NARROW-1:0]};
    end
  end

  assign mosi    = mosiQ;
  assign rxWord  = rxQ;
  assign doneStb = doneQ;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.drive || strb.prime) |=> $stable(mosiQ));
endmodule

// File: rtl/spiModeMaster.sv
module spiModeMaster
  import spiEngPkg::*;
#(
  parameter int DIV    = 2,
  parameter int NARROW = 8,
  parameter int WIDE   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            wide16,
  input  logic            holdSel,
  input  logic [WIDE-1:0] txWord,
  input  logic            startReq,
  output logic [WIDE-1:0] rxWord,
  output logic            doneStb,
  output logic            busy,
  output logic            sck,
  output logic            mosi,
  output logic            csN,
  input  logic            miso
);
  engStrobe_t strb;

  spiEngCtrl #(.DIV(DIV), .NARROW(NARROW), .WIDE(WIDE)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .holdSel(holdSel),
    .cpol(cpol), .cpha(cpha), .wide16(wide16),
    .strb(strb), .csN(csN), .sck(sck), .busy(busy)
  );

  spiEngData #(.NARROW(NARROW), .WIDE(WIDE)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txWord(txWord), .wide16(wide16),
    .miso(miso), .mosi(mosi), .rxWord(rxWord), .doneStb(doneStb)
  );
endmodule

// File: tb/tb_spiModeMaster.sv
module tb_spiModeMaster;
  localparam int DIV = 2;
  localparam int H   = DIV + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, wide16 = 1'b0, holdSel = 1'b0, startReq = 1'b0;
  logic [15:0] txWord = '0;
  logic [15:0] rxWord;
  logic doneStb, busy, sck, mosi, csN;
  logic miso = 1'b0;

  int total = 0, bad = 0;
  int doneCnt = 0, csRises = 0, sinceEvt = 0, edgesInFrame = 0, eIdx = 0;
  logic pCs = 1'b1, pSck = 1'b0, sPrevCs = 1'b1, sPrevSck = 1'b0, consumed = 1'b0;
  logic [15:0] expTx[$], expRx[$];
  int expW[$];
  logic sq[$], sIn[$];

  always #2 clk = ~clk;

  spiModeMaster #(.DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .wide16(wide16),
    .holdSel(holdSel), .txWord(txWord), .startReq(startReq), .rxWord(rxWord),
    .doneStb(doneStb), .busy(busy), .sck(sck), .mosi(mosi), .csN(csN), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic topBit(input logic [15:0] t, input int w);
    return (w == 16) ? t[15] : t[7];
  endfunction

  // behavioural peripheral: shifts out its queue, captures mosi
  always @(sck, csN) begin
    if (csN !== sPrevCs) begin
      sPrevCs = csN;
      if (csN === 1'b0) begin
        eIdx = 0;
        if (!cpha && sq.size() > 0) miso = sq[0];
      end else if (consumed) begin
        if (sq.size() > 0) void'(sq.pop_front());
        consumed = 1'b0;
      end
    end
    if (sck !== sPrevSck) begin
      sPrevSck = sck;
      if (csN === 1'b0) begin
        eIdx++;
        if (((eIdx % 2) == 1) ^ cpha) begin
          sIn.push_back(mosi);
          consumed = 1'b1;
        end else begin
          if (consumed && sq.size() > 0) begin
            void'(sq.pop_front());
            consumed = 1'b0;
          end
          miso = (sq.size() > 0) ? sq[0] : 1'b0;
        end
      end
    end
  end

  // reference model compared on every clock
  always @(negedge clk) begin
    if (rstN) begin
      sinceEvt++;
      if (csN != pCs) begin
        if (!csN) begin
          sinceEvt = 0;
          edgesInFrame = 0;
          if (!cpha && expTx.size() > 0)
            chk(mosi == topBit(expTx[0], expW[0]), "R3 preload", mosi, topBit(expTx[0], expW[0]));
        end else begin
          csRises++;
          chk(sinceEvt >= H, "R4 release gap", sinceEvt, H);
        end
        pCs = csN;
      end
      if (sck != pSck) begin
        if (!csN) begin
          if (edgesInFrame == 0) chk(sinceEvt >= H, "R4 lead", sinceEvt, H);
          else                   chk(sinceEvt == H, "R4 spacing", sinceEvt, H);
          edgesInFrame++;
          if (((edgesInFrame % 2) == 1) ^ cpha)
            chk(sck == (cpol == cpha), "R2 sample edge", sck, (cpol == cpha));
          if (edgesInFrame == 1 && cpha && expTx.size() > 0)
            chk(mosi == topBit(expTx[0], expW[0]), "R3 first edge", mosi, topBit(expTx[0], expW[0]));
        end
        sinceEvt = 0;
        pSck = sck;
      end
      if (csN) chk(sck == cpol, "R1 idle", sck, cpol);
      else if (!busy) chk(sck == cpol, "R8 hold level", sck, cpol);
      if (doneStb) begin
        int w;
        logic [15:0] got, ex, er;
        doneCnt++;
        w  = (expW.size() > 0) ? expW.pop_front() : 0;
        ex = (expTx.size() > 0) ? expTx.pop_front() : 16'h0;
        er = (expRx.size() > 0) ? expRx.pop_front() : 16'h0;
        chk(edgesInFrame == 2 * w, "R5 edges", edgesInFrame, 2 * w);
        chk(rxWord == er, "R6 rxWord", rxWord, er);
        got = '0;
        for (int i = 0; i < w; i++)
          got = {got[14:0], (sIn.size() > 0) ? sIn.pop_front() : 1'b0};
        chk(got == ex, "R2 mosi bits", got, ex);
        edgesInFrame = 0;
      end
    end
  end

  task automatic setMode(input logic c, input logic p);
    @(negedge clk);
    cpol = c;
    cpha = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic doFrame(input logic [15:0] tx, input logic [15:0] sl, input logic w16,
                         input logic hold, input int pokeAt);
    int w, tgt;
    w = w16 ? 16 : 8;
    while (busy) @(negedge clk);
    tgt = doneCnt + 1;
    expTx.push_back(w16 ? tx : {8'h00, tx[7:0]});
    expRx.push_back(w16 ? sl : {8'h00, sl[7:0]});
    expW.push_back(w);
    for (int i = w - 1; i >= 0; i--) sq.push_back(sl[i]);
    if (!consumed) miso = sq[0];
    txWord = tx; wide16 = w16; holdSel = hold; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (pokeAt > 0) begin
      repeat (pokeAt) @(negedge clk);
      txWord = 16'hFFFF; wide16 = 1'b1; holdSel = 1'b1; startReq = 1'b1;   // R7 poke
      @(negedge clk);
      startReq = 1'b0;
    end
    while (doneCnt < tgt) @(negedge clk);
    if (!hold) while (!csN) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    int d0, r0;
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R9 csN", csN, 1);
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(doneStb == 1'b0, "R9 done", doneStb, 0);
    chk(mosi == 1'b0, "R9 mosi", mosi, 0);
    chk(sck == cpol, "R9 sck", sck, cpol);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    setMode(0, 0); doFrame(16'hA5C3, 16'h3C96, 1, 0, 0);
    setMode(0, 1); doFrame(16'hFF5A, 16'h0081, 0, 0, 0);          // R5 narrow
    setMode(1, 0); doFrame(16'h1234, 16'hBEEF, 1, 0, 0);
    setMode(1, 1); doFrame(16'h00C7, 16'h0056, 0, 0, 0);
    setMode(0, 1); doFrame(16'h8001, 16'h7FFE, 1, 0, 0);          // last bit differs

    // R8 chained window, mode 0
    setMode(0, 0);
    r0 = csRises;
    doFrame(16'h0033, 16'h00CC, 0, 1, 0);
    chk(csN == 1'b0 && busy == 1'b0, "R8 window held", {csN, busy}, 0);
    doFrame(16'h9A9A, 16'h6565, 1, 1, 0);
    doFrame(16'h0071, 16'h008E, 0, 0, 0);
    chk(csRises == r0 + 1, "R8 one release", csRises, r0 + 1);

    // R8 chained window, mode 3
    setMode(1, 1);
    r0 = csRises;
    doFrame(16'hC0DE, 16'h1357, 1, 1, 0);
    doFrame(16'h00E9, 16'h0024, 0, 0, 0);
    chk(csRises == r0 + 1, "R8 one release mode3", csRises, r0 + 1);

    // R7 start while busy
    setMode(1, 0);
    d0 = doneCnt; r0 = csRises;
    doFrame(16'h0F0F, 16'hF00D, 1, 0, 20);
    repeat (40) @(negedge clk);
    chk(doneCnt == d0 + 1, "R7 frames", doneCnt, d0 + 1);
    chk(csRises == r0 + 1, "R7 releases", csRises, r0 + 1);
    chk(csN == 1'b1 && busy == 1'b0, "R7 idle after", {csN, busy}, 2);

    summary();
  end
endmodule